// File: doc/BRIEF.md
# Configurable Output Macrocell Slice

This block is a row of per-pin output cells that sit between a sum-of-products logic array and a set of bidirectional pins. Each cell receives the OR-ed sum term for its pin and a dedicated output-enable product term. A shared clock, a shared global enable input and a shared test preload strobe serve all cells. A 3-bit configuration field for each cell selects one of eight operating modes. The all-zero setting gives a registered, active-low output whose enable comes from the product term.

The cell holds a D flip-flop that samples the sum term on every rising clock edge. In registered mode the pin shows that flip-flop. In combinational mode the pin follows the sum term directly. A polarity bit decides whether the pin carries the selected value or its complement. The cell also returns one signal to the array. In registered mode this is the flip-flop state in true polarity. In combinational mode it is the value read from the pin, so a disabled pin serves as an extra input. The pin appears as three separate signals: drive value, drive enable and read value.

Top module: `out_macrocell`

## Requirements
- R1: Configuration bit 0 sets polarity. With 1, `pin_out` equals the selected value (flip-flop or sum term). With 0, it is the complement of that value.
- R2: With configuration bit 1 set to 1 (combinational), `pin_out` follows that lane's `sum_term` in the same cycle, with polarity applied.
- R3: With configuration bit 1 set to 0 (registered), `pin_out` shows the `sum_term` sampled at the previous rising clock edge, with polarity applied.
- R4: Configuration bit 2 selects the enable source. With 0, `pin_oe` equals the lane's `oe_term`. With 1, it equals the shared `glob_oe`.
- R5: A rising edge with `rst_n` low clears every flip-flop. After reset, a registered active-low lane drives `pin_out` = 1, a registered active-high lane drives 0, and registered feedback is 0.
- R6: When `preload_en` is high at a rising edge (and `rst_n` is high), each flip-flop loads its lane of `preload_val` instead of `sum_term`.
- R7: In registered mode, `fb_out` equals the flip-flop state in true polarity, whatever the polarity bit says.
- R8: In combinational mode, `fb_out` equals that lane's `pin_in`.
- R9: The flip-flop keeps sampling `sum_term` while its lane is in combinational mode. Switching the lane to registered shows that state on `pin_out` at once.
- R10: Each lane follows only its own 3-bit configuration field, at bits [3*i+2 : 3*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of all flip-flops |
| cfg_bits | input | 3*LANES | Per-lane mode field: bit0 polarity, bit1 combinational, bit2 global enable |
| sum_term | input | LANES | OR-ed sum term per lane |
| oe_term | input | LANES | Enable product term per lane |
| glob_oe | input | 1 | Shared enable input |
| preload_en | input | 1 | Test strobe that loads the flip-flops |
| preload_val | input | LANES | Value loaded into each flip-flop on preload |
| pin_in | input | LANES | Value read back from each pin |
| pin_out | output | LANES | Value driven onto each pin |
| pin_oe | output | LANES | Drive enable per pin |
| fb_out | output | LANES | Feedback to the array per lane |

## Verification
Suppose a flip-flop holds a wrong value. A registered lane then shows it on `pin_out` at the next sample after the bad edge, with polarity applied, and on `fb_out` in true polarity. A combinational lane hides the error until its mode changes to registered, and then it appears within the same cycle. A swapped selector, such as the enable source or the feedback source, shows up as soon as the two candidate inputs differ. The bench therefore drives those inputs to opposite values across all eight modes.

// File: rtl/out_macrocell_pkg.sv
// Shared types for the output macrocell slice.
// Field order matters: the 3-bit per-lane configuration word is sliced
// directly into this struct (bit2 enable source, bit1 path, bit0 polarity).
package out_macrocell_pkg;

    typedef struct packed {
        logic oe_from_pin;   // 1: shared enable input, 0: product term
        logic comb_path;     // 1: combinational, 0: registered
        logic act_high;      // 1: true polarity, 0: inverted
    } mc_cfg_t;

    localparam int unsigned CFG_W = $bits(mc_cfg_t);

endpackage

// File: rtl/mc_cell_reg.sv
// Storage element of one output cell.
// Samples the sum term each rising edge. The test preload overrides the
// sum term and reset overrides both. Assumes a synchronous active-low
// reset that is shared with the rest of the slice.
module mc_cell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    input  logic pl_en,
    input  logic pl_val,
    output logic q
);

    // State update: reset, then preload, then normal sampling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (pl_en)
            q <= pl_val;
        else
            q <= d_in;
    end

endmodule

// File: rtl/mc_oe_sel.sv
// Output-enable source selector for one cell.
// Purely combinational. Assumes both enable sources are already active-high.
module mc_oe_sel (
    input  logic use_pin,
    input  logic term_oe,
    input  logic shared_oe,
    output logic oe
);

    // Pick the enable source named by the configuration.
    always_comb begin
        oe = use_pin ? shared_oe : term_oe;
    end

endmodule

// File: rtl/mc_cell_path.sv
// Data path of one output cell: chooses the registered or the direct
// value, applies polarity, and picks the feedback source.
// Assumes the flip-flop state arrives in true polarity.
module mc_cell_path
    import out_macrocell_pkg::*;
(
    input  mc_cfg_t cfg,
    input  logic    sum_in,
    input  logic    q_in,
    input  logic    pad_in,
    output logic    drive,
    output logic    fb
);

    logic sel_val;

    // Choose the value before polarity is applied.
    always_comb begin
        sel_val = cfg.comb_path ? sum_in : q_in;
    end

    // Apply output polarity.
    always_comb begin
        drive = cfg.act_high ? sel_val : ~sel_val;
    end

    // Feedback comes from the pin in combinational mode, else from state.
    always_comb begin
        fb = cfg.comb_path ? pad_in : q_in;
    end

endmodule

// File: rtl/out_macrocell.sv
// Slice of LANES configurable output cells that share a clock, a global
// enable and a preload strobe. Each lane decodes its own 3-bit field of
// cfg_bits. Assumes a synchronous active-low reset. The pin is split into
// separate drive, enable and read signals.
module out_macrocell
    import out_macrocell_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CFG_W*LANES-1:0] cfg_bits,
    input  logic [LANES-1:0]       sum_term,
    input  logic [LANES-1:0]       oe_term,
    input  logic                   glob_oe,
    input  logic                   preload_en,
    input  logic [LANES-1:0]       preload_val,
    input  logic [LANES-1:0]       pin_in,
    output logic [LANES-1:0]       pin_out,
    output logic [LANES-1:0]       pin_oe,
    output logic [LANES-1:0]       fb_out
);

    logic [LANES-1:0] lane_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        mc_cfg_t cfg_l;

        // Slice this lane's configuration field (R10).
        always_comb begin
            cfg_l = mc_cfg_t'(cfg_bits[CFG_W*i +: CFG_W]);
        end

        mc_cell_reg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_in   (sum_term[i]),
            .pl_en  (preload_en),
            .pl_val (preload_val[i]),
            .q      (lane_q[i])
        );

        mc_oe_sel u_oe (
            .use_pin   (cfg_l.oe_from_pin),
            .term_oe   (oe_term[i]),
            .shared_oe (glob_oe),
            .oe        (pin_oe[i])
        );

        mc_cell_path u_path (
            .cfg    (cfg_l),
            .sum_in (sum_term[i]),
            .q_in   (lane_q[i]),
            .pad_in (pin_in[i]),
            .drive  (pin_out[i]),
            .fb     (fb_out[i])
        );

        // R3
        reg_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(preload_en) && !cfg_l.comb_path)
            |-> (pin_out[i] == (cfg_l.act_high ? $past(sum_term[i]) : !$past(sum_term[i]))));

        // R6
        preload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(preload_en)) |-> (lane_q[i] == $past(preload_val[i])));

        // R5
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (lane_q[i] == 1'b0));

        // R8
        comb_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_l.comb_path |-> (fb_out[i] == pin_in[i]));

        // R7
        reg_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_l.comb_path |-> (fb_out[i] == lane_q[i]));

        // R4
        oe_pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_l.oe_from_pin |-> (pin_oe[i] == glob_oe));

        // R4
        oe_term_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_l.oe_from_pin |-> (pin_oe[i] == oe_term[i]));
    end

endmodule

// File: tb/sim_out_macrocell.sv
module sim_out_macrocell;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3*L-1:0] cfg_bits = '0;
    logic [L-1:0]   sum_term = '0, oe_term = '0, preload_val = '0, pin_in = '0;
    logic           glob_oe = 1'b0, preload_en = 1'b0;
    logic [L-1:0]   pin_out, pin_oe, fb_out;
    logic [L-1:0]   mq;
    int             n_cmp = 0, n_bad = 0;
    bit             done = 0;

    always #2 clk = ~clk;

    out_macrocell #(.LANES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .sum_term(sum_term),
        .oe_term(oe_term), .glob_oe(glob_oe), .preload_en(preload_en),
        .preload_val(preload_val), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .fb_out(fb_out)
    );

    function automatic logic [L-1:0] exp_out(logic [3*L-1:0] c, logic [L-1:0] s, logic [L-1:0] q);
        logic [L-1:0] r;
        for (int i = 0; i < L; i++) begin
            logic v;
            v = c[3*i+1] ? s[i] : q[i];
            r[i] = c[3*i] ? v : ~v;
        end
        return r;
    endfunction

    function automatic logic [L-1:0] exp_oe(logic [3*L-1:0] c, logic [L-1:0] o, logic g);
        logic [L-1:0] r;
        for (int i = 0; i < L; i++) r[i] = c[3*i+2] ? g : o[i];
        return r;
    endfunction

    function automatic logic [L-1:0] exp_fb(logic [3*L-1:0] c, logic [L-1:0] p, logic [L-1:0] q);
        logic [L-1:0] r;
        for (int i = 0; i < L; i++) r[i] = c[3*i+1] ? p[i] : q[i];
        return r;
    endfunction

    task automatic cmp(string tag, logic [L-1:0] act, logic [L-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, check 1 ns later, then advance the model at the rising edge.
    task automatic step(logic [3*L-1:0] c, logic [L-1:0] s, logic [L-1:0] o, logic g,
                        logic pe, logic [L-1:0] pv, logic [L-1:0] pi, logic rn,
                        bit chk, string tag);
        @(negedge clk);
        cfg_bits = c; sum_term = s; oe_term = o; glob_oe = g;
        preload_en = pe; preload_val = pv; pin_in = pi; rst_n = rn;
        #1;
        if (chk) begin
            cmp({tag, " pin_out R1/R2/R3"}, pin_out, exp_out(c, s, mq));
            cmp({tag, " pin_oe R4"}, pin_oe, exp_oe(c, o, g));
            cmp({tag, " fb_out R7/R8"}, fb_out, exp_fb(c, pi, mq));
        end
        @(posedge clk);
        if (!rn) mq = '0;
        else if (pe) mq = pv;
        else mq = s;
    endtask

    function automatic logic [3*L-1:0] rep(logic [2:0] m);
        return {L{m}};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mq = 'x;
        step('0, '1, '0, 1'b0, 1'b0, '0, '0, 1'b0, 0, "init");
        step('0, '1, '0, 1'b0, 1'b0, '0, '0, 1'b0, 0, "init");
        // R5: registered active-low lanes drive 1 after reset, feedback 0
        step(rep(3'b000), 4'b0000, 4'b1111, 1'b0, 1'b0, '0, 4'b1010, 1'b1, 1, "R5 low");
        step(rep(3'b000), 4'b1111, 4'b1111, 1'b0, 1'b0, '0, 4'b1010, 1'b0, 1, "R5 prep");
        step(rep(3'b001), 4'b1111, 4'b0000, 1'b1, 1'b0, '0, 4'b0101, 1'b1, 1, "R5 high");
        // Sweep all eight modes with opposite values on each candidate source
        for (int m = 0; m < 8; m++) begin
            step(rep(m[2:0]), 4'b1001, 4'b0110, 1'b1, 1'b0, '0, 4'b0011, 1'b1, 1, "sweep a");
            step(rep(m[2:0]), 4'b0110, 4'b1001, 1'b0, 1'b0, '0, 4'b1100, 1'b1, 1, "sweep b");
        end
        // R6: preload beats a conflicting sum term
        step(rep(3'b001), 4'b1111, 4'b0000, 1'b0, 1'b1, 4'b0101, '0, 1'b1, 1, "R6 load");
        step(rep(3'b001), 4'b1111, 4'b0000, 1'b0, 1'b0, '0, '0, 1'b1, 1, "R6 see");
        step(rep(3'b000), 4'b0000, 4'b0000, 1'b0, 1'b1, 4'b1100, '0, 1'b1, 1, "R6 load2");
        step(rep(3'b000), 4'b0000, 4'b0000, 1'b0, 1'b0, '0, '0, 1'b1, 1, "R6 see2");
        // R9: flip-flop samples in combinational mode, visible after the switch
        step(rep(3'b011), 4'b1011, 4'b0000, 1'b0, 1'b0, '0, 4'b0100, 1'b1, 1, "R9 comb");
        step(rep(3'b001), 4'b0000, 4'b0000, 1'b0, 1'b0, '0, 4'b0000, 1'b1, 1, "R9 reg");
        // R10: mixed per-lane fields
        step(12'b111_010_101_000, 4'b1010, 4'b0101, 1'b1, 1'b0, '0, 4'b0110, 1'b1, 1, "R10 mix");
        step(12'b000_101_010_111, 4'b0101, 4'b1010, 1'b0, 1'b0, '0, 4'b1001, 1'b1, 1, "R10 mix2");
        // Random traffic, occasional preload and reset
        for (int k = 0; k < 600; k++) begin
            step($urandom(), $urandom(), $urandom(), $urandom(),
                 ($urandom() % 8) == 0, $urandom(), $urandom(),
                 ($urandom() % 32) != 0, 1, "rand");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule